// File: doc/BRIEF.md
# Per-Source Configurable Interrupt Generator

This block gathers a set of interrupt condition inputs and folds them into a single interrupt pin. Each source gets its own 2-bit trigger code. The code selects one of four behaviours: latch when the condition appears, latch when it goes away, follow the condition while it is present, or stay inert. The two bits of each code are kept in two separate registers. One register holds the upper bit of every source. The other holds the lower bit, at the same bit position.

For the edge modes, each source keeps a sticky status bit, which software clears by writing a one to it. A mask register chooses which status bits may reach the interrupt pin. A separate 2-bit pin-control field sets the electrical form of the pin: active-high, active-low, or a low-only drive that releases the pin when it is idle. The trigger codes have no effect on this. Software reaches everything through a small synchronous register port. The read data is registered.

Top module: `irq_gen_top`

## Requirements
- R1: Source i takes its trigger code as {MODE_HI[i], MODE_LO[i]}. MODE_HI is at address 0 and MODE_LO at address 1. Code 00 = rising, 01 = falling, 10 = level, 11 = inert.
- R2: In rising mode, a 0-to-1 change of the sampled condition sets status bit i. The bit stays set after the condition drops.
- R3: In falling mode, only a 1-to-0 change of the sampled condition sets status bit i.
- R4: In level mode, status bit i equals the condition sampled one cycle earlier, and a write-one-to-clear has no effect on it.
- R5: Code 11 never sets status bit i, whatever the condition does.
- R6: Writing the status register (address 4) clears each edge-mode status bit written as 1. Bits written as 0 are kept. A new edge in the same cycle as a clear leaves the bit set.
- R7: The interrupt is active exactly when some status bit is set whose bit in the mask register (address 2) is 1.
- R8: The pin-control field (address 3, bits 1:0) sets the pin. 00 gives irq_o = active, irq_oe = 1. 01 and 11 give irq_o = not active, irq_oe = 1. 10 gives irq_o = 0, irq_oe = active.
- R9: A condition pulse lasting one clock is seen as both a rising and a falling edge.
- R10: After reset, all registers read 0, every source is in rising mode, and the pin is idle (irq_o = 0, irq_oe = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | NSRC | Interrupt condition per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 hi-mode, 1 lo-mode, 2 mask, 3 pin control, 4 status) |
| reg_wdata | input | NSRC | Register write data |
| reg_rdata | output | NSRC | Registered read data for reg_addr of the previous cycle |
| irq_o | output | 1 | Value driven on the interrupt pin |
| irq_oe | output | 1 | Drive enable of the interrupt pin |

## Verification
The assertions assume that cond_i is synchronous to clk and changes only between edges. They also assume that a write strobe carries a defined address. The bench drives all inputs on the falling edge and holds reg_addr steady while a read is pending. It returns the conditions to 0 before it reprograms the trigger codes, so that a mode change never meets an edge that was not intended. It creates the same-cycle set-and-clear case on purpose, by placing a status write in the cycle in which a rising edge is detected.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MODE_HI = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK    = 3'd2;
  localparam logic [ADDR_W-1:0] A_PINCTL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd4;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'b00,
    TRIG_FALL  = 2'b01,
    TRIG_LEVEL = 2'b10,
    TRIG_NONE  = 2'b11
  } trig_e;

  typedef enum logic [1:0] {
    PIN_HIGH    = 2'b00,
    PIN_LOW     = 2'b01,
    PIN_LOW_REL = 2'b10,
    PIN_RSVD    = 2'b11
  } pin_e;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wdata,
  input  logic [NSRC-1:0]   status,
  output logic [NSRC-1:0]   rdata,
  output logic [NSRC-1:0]   mode_hi,
  output logic [NSRC-1:0]   mode_lo,
  output logic [NSRC-1:0]   mask,
  output logic [1:0]        pinctl,
  output logic [NSRC-1:0]   clr
);
  localparam int PAD = NSRC - 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_hi <= '0;
      mode_lo <= '0;
      mask    <= '0;
      pinctl  <= 2'b00;
    end else if (we) begin
      case (addr)
        A_MODE_HI: mode_hi <= wdata;
        A_MODE_LO: mode_lo <= wdata;
        A_MASK:    mask    <= wdata;
        A_PINCTL:  pinctl  <= wdata[1:0];
        default:   ;
      endcase
    end
  end

  always_comb clr = (we && addr == A_STATUS) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        A_MODE_HI: rdata <= mode_hi;
        A_MODE_LO: rdata <= mode_lo;
        A_MASK:    rdata <= mask;
        A_PINCTL:  rdata <= {{PAD{1'b0}}, pinctl};
        A_STATUS:  rdata <= status;
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cond_i,
  input  logic [1:0] mode,
  input  logic       clr,
  output logic       status_o,
  output logic       cond_s_o
);
  logic cond_s, cond_p, st, st_nxt;
  logic rise, fall;

  always_comb begin
    rise = cond_s & ~cond_p;
    fall = ~cond_s & cond_p;
    case (trig_e'(mode))
      TRIG_RISE:  st_nxt = rise | (st & ~clr);
      TRIG_FALL:  st_nxt = fall | (st & ~clr);
      TRIG_LEVEL: st_nxt = cond_s;
      default:    st_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_s <= 1'b0;
      cond_p <= 1'b0;
      st     <= 1'b0;
    end else begin
      cond_s <= cond_i;
      cond_p <= cond_s;
      st     <= st_nxt;
    end
  end

  assign status_o = st;
  assign cond_s_o = cond_s;
endmodule

// File: rtl/irq_pin_stage.sv
module irq_pin_stage
  import irq_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] status,
  input  logic [NSRC-1:0] mask,
  input  logic [1:0]      pinctl,
  output logic            irq_o,
  output logic            irq_oe
);
  logic act, drv_n, oe_n;

  always_comb begin
    act = |(status & mask);
    case (pin_e'(pinctl))
      PIN_HIGH:    begin drv_n = act;  oe_n = 1'b1; end
      PIN_LOW_REL: begin drv_n = 1'b0; oe_n = act;  end
      default:     begin drv_n = ~act; oe_n = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      irq_oe <= 1'b1;
    end else begin
      irq_o  <= drv_n;
      irq_oe <= oe_n;
    end
  end
endmodule

// File: rtl/irq_gen_top.sv
module irq_gen_top
  import irq_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   cond_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata,
  output logic              irq_o,
  output logic              irq_oe
);
  logic [NSRC-1:0] src_status, cond_s, cfg_hi, cfg_lo, cfg_mask, clr_vec;
  logic [1:0]      cfg_pin;

  irq_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .status(src_status), .rdata(reg_rdata), .mode_hi(cfg_hi),
    .mode_lo(cfg_lo), .mask(cfg_mask), .pinctl(cfg_pin), .clr(clr_vec)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    irq_src_cell u_cell (
      .clk(clk), .rst(rst), .cond_i(cond_i[i]),
      .mode({cfg_hi[i], cfg_lo[i]}), .clr(clr_vec[i]),
      .status_o(src_status[i]), .cond_s_o(cond_s[i])
    );
  end

  irq_pin_stage #(.NSRC(NSRC)) u_pin (
    .clk(clk), .rst(rst), .status(src_status), .mask(cfg_mask),
    .pinctl(cfg_pin), .irq_o(irq_o), .irq_oe(irq_oe)
  );
endmodule

// File: rtl/irq_gen_chk.sv
module irq_gen_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] status,
  input logic [NSRC-1:0] cond_s,
  input logic [NSRC-1:0] hi,
  input logic [NSRC-1:0] lo,
  input logic [NSRC-1:0] mask,
  input logic [1:0]      pinctl,
  input logic [NSRC-1:0] clr,
  input logic            irq_o,
  input logic            irq_oe
);
  logic [NSRC-1:0] inert, lvl, keep;
  always_comb begin
    inert = hi & lo;
    lvl   = hi & ~lo;
    keep  = status & ~hi & ~clr;
  end

  // R5: inert sources end every cycle cleared
  p_inert_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & $past(inert)) == '0));

  // R4: level sources track the sampled condition
  p_level_follow_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & $past(lvl)) == ($past(cond_s) & $past(lvl))));

  // R6: edge-mode bits not cleared stay set
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & $past(keep)) == $past(keep)));

  // R7: nothing unmasked under active-high means the pin stays low
  p_masked_idle_r7: assert property (@(posedge clk) disable iff (rst)
    ((status & mask) == '0 && pinctl == 2'b00) |=> !irq_o);

  // R8: push-pull settings always drive
  p_pushpull_r8: assert property (@(posedge clk) disable iff (rst)
    (pinctl != 2'b10) |=> irq_oe);

  // R8: low-only setting never drives high
  p_od_low_r8: assert property (@(posedge clk) disable iff (rst)
    (pinctl == 2'b10) |=> !irq_o);
endmodule

bind irq_gen_top irq_gen_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .status(src_status), .cond_s(cond_s),
  .hi(cfg_hi), .lo(cfg_lo), .mask(cfg_mask), .pinctl(cfg_pin),
  .clr(clr_vec), .irq_o(irq_o), .irq_oe(irq_oe)
);

// File: tb/tb_irq_gen_top.sv
module tb_irq_gen_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] cond_i = '0;
  logic            reg_we = 1'b0;
  logic [2:0]      reg_addr = '0;
  logic [NSRC-1:0] reg_wdata = '0;
  logic [NSRC-1:0] reg_rdata;
  logic            irq_o, irq_oe;

  irq_gen_top #(.NSRC(NSRC)) dut (
    .clk(clk), .rst(rst), .cond_i(cond_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .irq_oe(irq_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_cmp = 0, n_bad = 0;
  bit    cap = 1'b0, done = 1'b0;
  int    exp_q[$];
  int    kind_q[$];
  string tag_q[$];

  // monitor: pops one expectation per capture window
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (cap && exp_q.size() > 0) begin
        int e, k, a;
        string t;
        e = exp_q.pop_front();
        k = kind_q.pop_front();
        t = tag_q.pop_front();
        a = (k == 0) ? int'(reg_rdata) : (k == 1) ? int'(irq_o) : int'(irq_oe);
        n_cmp++;
        if (a != e) begin
          n_bad++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", t, a, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [NSRC-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic expect_item(input int kind, input logic [2:0] a,
                             input int e, input string t);
    @(negedge clk);
    reg_addr = a;
    exp_q.push_back(e); kind_q.push_back(kind); tag_q.push_back(t);
    cap = 1'b1;
    @(negedge clk);
    cap = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input int e, input string t);
    expect_item(0, a, e, t);
  endtask

  task automatic pin(input int o, input int oe, input string t);
    expect_item(1, 3'd0, o, t);
    expect_item(2, 3'd0, oe, t);
  endtask

  task automatic set_cond(input int i, input logic v);
    @(negedge clk);
    cond_i[i] = v;
    idle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R10: reset state
    rd(3'd0, 0, "R10 mode_hi");
    rd(3'd1, 0, "R10 mode_lo");
    rd(3'd2, 0, "R10 mask");
    rd(3'd3, 0, "R10 pinctl");
    rd(3'd4, 0, "R10 status");
    pin(0, 1, "R10 pin idle");

    wr(3'd2, 8'hFF);
    // R2: rising edge latches and stays
    set_cond(0, 1'b1);
    rd(3'd4, 8'h01, "R2 rise sets");
    pin(1, 1, "R2 pin active");
    set_cond(0, 1'b0);
    rd(3'd4, 8'h01, "R2 sticky after drop");

    // R6: zero write keeps, one write clears
    wr(3'd4, 8'h00);
    rd(3'd4, 8'h01, "R6 zero write kept");
    wr(3'd4, 8'h01);
    idle(1);
    rd(3'd4, 8'h00, "R6 one write clears");
    pin(0, 1, "R6 pin idle");

    // R1, R3: low-bit register alone makes source 1 falling
    wr(3'd1, 8'h02);
    rd(3'd1, 8'h02, "R1 mode_lo readback");
    set_cond(1, 1'b1);
    rd(3'd4, 8'h00, "R3 no set on rise");
    set_cond(1, 1'b0);
    rd(3'd4, 8'h02, "R3 set on fall");
    wr(3'd4, 8'h02);

    // R1, R4: high bit makes source 2 level
    wr(3'd0, 8'h04);
    set_cond(2, 1'b1);
    rd(3'd4, 8'h04, "R4 level present");
    wr(3'd4, 8'h04);
    idle(1);
    rd(3'd4, 8'h04, "R4 clear ignored");
    set_cond(2, 1'b0);
    rd(3'd4, 8'h00, "R4 level gone");

    // R5: code 11 on source 3
    wr(3'd0, 8'h0C);
    wr(3'd1, 8'h0A);
    set_cond(3, 1'b1);
    rd(3'd4, 8'h00, "R5 inert rise");
    set_cond(3, 1'b0);
    rd(3'd4, 8'h00, "R5 inert fall");

    // R9: one-cycle pulse on src4 (rise) and src5 (fall)
    wr(3'd1, 8'h2A);
    @(negedge clk);
    cond_i[4] = 1'b1; cond_i[5] = 1'b1;
    @(negedge clk);
    cond_i[4] = 1'b0; cond_i[5] = 1'b0;
    idle(3);
    rd(3'd4, 8'h30, "R9 pulse both edges");
    wr(3'd4, 8'h20);
    idle(1);
    rd(3'd4, 8'h10, "R6 partial clear");

    // R7: mask gating
    wr(3'd2, 8'h01);
    idle(1);
    pin(0, 1, "R7 masked off");
    wr(3'd2, 8'h10);
    idle(1);
    pin(1, 1, "R7 unmasked on");

    // R8: pin forms with interrupt active
    wr(3'd3, 8'h01);
    idle(1);
    pin(0, 1, "R8 active-low active");
    wr(3'd3, 8'h02);
    idle(1);
    pin(0, 1, "R8 low-only active");
    wr(3'd3, 8'h03);
    idle(1);
    pin(0, 1, "R8 code 11 active");
    rd(3'd3, 3, "R8 pinctl readback");
    wr(3'd4, 8'h10);
    idle(1);
    pin(1, 1, "R8 code 11 idle");
    wr(3'd3, 8'h02);
    idle(1);
    pin(0, 0, "R8 low-only released");
    wr(3'd3, 8'h01);
    idle(1);
    pin(1, 1, "R8 active-low idle");

    // R6: edge and clear in the same cycle, edge wins
    wr(3'd3, 8'h00);
    @(negedge clk);
    cond_i[0] = 1'b1;
    wr(3'd4, 8'h01);
    idle(2);
    rd(3'd4, 8'h01, "R6 set beats clear");
    cond_i[0] = 1'b0;

    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule